// File: doc/BRIEF.md
# Neuron-Chunk Grid Sequencer

This block is the control engine that frames work for a chunked dot-product accumulator. A layer is a rectangular grid: a number of neurons, each split into the same number of input chunks. After a single start pulse the sequencer visits every grid point exactly once, one point per clock. It finishes all chunks of a neuron before moving to the next neuron. For each point it presents the neuron index and the chunk index.

On every visited point the block raises a valid strobe. It also raises two framing flags. The first-chunk flag tells the accumulator to begin a fresh sum. The last-chunk flag tells it that the sum for the current neuron is complete. When the final chunk of the final neuron has been issued, the block emits a one-cycle done pulse and returns to idle, ready for the next start.

Both grid dimensions are elaboration parameters. Each must be at least 1. The degenerate shapes are legal: a single chunk per neuron, a single neuron, or a 1x1 grid.

Top module: `grid_walker`

## Requirements
- R1: While rstN is low, and on the first cycle after its release, valid, firstChunk, lastChunk and done are 0 and neuronId and chunkId are 0.
- R2: A start sampled high while idle makes valid high on the following cycle, with neuronId = 0 and chunkId = 0.
- R3: A pass is NEURONS*CHUNKS consecutive valid cycles. In valid cycle t (counting from 0), neuronId = t / CHUNKS and chunkId = t mod CHUNKS, so chunkId is the inner loop.
- R4: firstChunk is 1 exactly on valid cycles with chunkId = 0, and is 0 otherwise.
- R5: lastChunk is 1 exactly on valid cycles with chunkId = CHUNKS-1, and is 0 otherwise.
- R6: done is 1 for exactly one cycle, namely the cycle right after the last grid point (neuronId = NEURONS-1, chunkId = CHUNKS-1). valid is 0 in that cycle.
- R7: On the cycle after done the block is idle, and a start sampled on that cycle launches a new pass per R2.
- R8: start sampled while a pass is running, or on the done cycle, has no effect on the indices, the strobes or the pass length.
- R9: valid is 0 whenever no pass is running. Outside a pass, neuronId and chunkId read 0.
- R10: NEURONS and CHUNKS must each be at least 1. With CHUNKS = 1, firstChunk and lastChunk are both 1 on every valid cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launches a pass when sampled high while idle |
| neuronId | output | NW (clog2 of NEURONS, min 1) | Neuron index of the current grid point |
| chunkId | output | CW (clog2 of CHUNKS, min 1) | Chunk index of the current grid point |
| valid | output | 1 | High on every cycle that presents a grid point |
| firstChunk | output | 1 | Current point is chunk 0 of its neuron |
| lastChunk | output | 1 | Current point is the final chunk of its neuron |
| done | output | 1 | One-cycle pulse after the final grid point |

## Verification
The properties place no constraint on start. It may be high on any cycle, held for many cycles, or pulsed on the done cycle. The only assumption is that start is a synchronous signal that is stable around the rising edge. The bench meets this by changing start and rstN only on falling edges.

The bench runs four grid shapes in parallel: 3x4, 1x1, 2x1 and 1x3. They share the same start and reset, so a single stream of held and pulsed starts lands on idle, running and done cycles for the different shapes at different times. Each shape is compared every cycle against an arithmetic position-in-pass model.

// File: rtl/grid_walker_pkg.sv
package grid_walker_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } walkState_t;

  // strobes from control to the index datapath
  typedef struct packed {
    logic clear;    // zero both indices
    logic advance;  // move to the next grid point
  } walkCmd_t;

  function automatic int idxWidth(input int count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction

endpackage

// File: rtl/grid_walker_ctrl.sv
module grid_walker_ctrl
  import grid_walker_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       gridEnd,
  output walkState_t state,
  output walkCmd_t   cmd
);

  walkState_t nextState;

  always_comb begin
    nextState   = state;
    cmd.clear   = 1'b0;
    cmd.advance = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          nextState = ST_RUN;
          cmd.clear = 1'b1;
        end
      end
      ST_RUN: begin
        cmd.advance = 1'b1;
        if (gridEnd) nextState = ST_DONE;
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

endmodule

// File: rtl/grid_walker_idx.sv
module grid_walker_idx
  import grid_walker_pkg::*;
#(
  parameter int NEURONS = 3,
  parameter int CHUNKS  = 4,
  localparam int NW = idxWidth(NEURONS),
  localparam int CW = idxWidth(CHUNKS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  walkCmd_t      cmd,
  output logic [NW-1:0] neuronIdx,
  output logic [CW-1:0] chunkIdx,
  output logic          chunkAtEnd,
  output logic          gridEnd
);

  localparam logic [NW-1:0] NEURON_MAX = NW'(NEURONS - 1);
  localparam logic [CW-1:0] CHUNK_MAX  = CW'(CHUNKS - 1);

  logic neuronAtEnd;

  // inner loop: chunk index
  generate
    if (CHUNKS == 1) begin : g_chunkFixed
      assign chunkIdx   = '0;
      assign chunkAtEnd = 1'b1;
    end else begin : g_chunkCount
      logic [CW-1:0] chunkQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                     chunkQ <= '0;
        else if (cmd.clear)            chunkQ <= '0;
        else if (cmd.advance) begin
          if (chunkQ == CHUNK_MAX)     chunkQ <= '0;
          else                         chunkQ <= chunkQ + 1'b1;
        end
      end
      assign chunkIdx   = chunkQ;
      assign chunkAtEnd = (chunkQ == CHUNK_MAX);
    end
  endgenerate

  // outer loop: neuron index, steps when the inner loop wraps
  generate
    if (NEURONS == 1) begin : g_neuronFixed
      assign neuronIdx   = '0;
      assign neuronAtEnd = 1'b1;
    end else begin : g_neuronCount
      logic [NW-1:0] neuronQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                        neuronQ <= '0;
        else if (cmd.clear)               neuronQ <= '0;
        else if (cmd.advance && chunkAtEnd) begin
          if (neuronQ == NEURON_MAX)      neuronQ <= '0;
          else                            neuronQ <= neuronQ + 1'b1;
        end
      end
      assign neuronIdx   = neuronQ;
      assign neuronAtEnd = (neuronQ == NEURON_MAX);
    end
  endgenerate

  assign gridEnd = chunkAtEnd && neuronAtEnd;

endmodule

// File: rtl/grid_walker.sv
module grid_walker
  import grid_walker_pkg::*;
#(
  parameter int NEURONS = 3,
  parameter int CHUNKS  = 4,
  localparam int NW = idxWidth(NEURONS),
  localparam int CW = idxWidth(CHUNKS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  output logic [NW-1:0] neuronId,
  output logic [CW-1:0] chunkId,
  output logic          valid,
  output logic          firstChunk,
  output logic          lastChunk,
  output logic          done
);

  // R10: both grid dimensions must be at least 1
  generate
    if (NEURONS < 1 || CHUNKS < 1) begin : g_badShape
      $error("grid_walker: NEURONS and CHUNKS must be >= 1");
    end
  endgenerate

  walkState_t state;
  walkCmd_t   cmd;
  logic       gridEnd;
  logic       chunkAtEnd;

  grid_walker_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .gridEnd (gridEnd),
    .state   (state),
    .cmd     (cmd)
  );

  grid_walker_idx #(
    .NEURONS (NEURONS),
    .CHUNKS  (CHUNKS)
  ) u_idx (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cmd),
    .neuronIdx  (neuronId),
    .chunkIdx   (chunkId),
    .chunkAtEnd (chunkAtEnd),
    .gridEnd    (gridEnd)
  );

  assign valid      = (state == ST_RUN);
  assign done       = (state == ST_DONE);
  assign firstChunk = valid && (chunkId == '0);
  assign lastChunk  = valid && chunkAtEnd;

endmodule

// File: rtl/grid_walker_chk.sv
module grid_walker_chk #(
  parameter int NEURONS = 3,
  parameter int CHUNKS  = 4,
  parameter int NW = 2,
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic [NW-1:0] neuronId,
  input logic [CW-1:0] chunkId,
  input logic          valid,
  input logic          firstChunk,
  input logic          lastChunk,
  input logic          done
);

  logic atFinal;
  assign atFinal = lastChunk && (neuronId == NW'(NEURONS - 1));

  // R2
  launch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!valid && !done && start) |=> (valid && chunkId == '0 && neuronId == '0));

  // R3
  inner_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (valid && !lastChunk) |=>
      (valid && chunkId == CW'($past(chunkId) + 1'b1) && $stable(neuronId)));

  // R3
  outer_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (valid && lastChunk && !atFinal) |=>
      (valid && chunkId == '0 && neuronId == NW'($past(neuronId) + 1'b1)));

  // R4
  first_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    firstChunk == (valid && chunkId == '0));

  // R5
  last_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    lastChunk == (valid && chunkId == CW'(CHUNKS - 1)));

  // R6
  done_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    (valid && atFinal) |=> (done && !valid));

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R7
  back_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !valid);

  // R8
  run_ignores_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && start) |=> (!valid && !done));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !valid |-> (neuronId == '0 && chunkId == '0 && !firstChunk && !lastChunk));

  // R10
  single_chunk_chk: assert property (@(posedge clk) disable iff (!rstN)
    (CHUNKS == 1 && valid) |-> (firstChunk && lastChunk));

endmodule

bind grid_walker grid_walker_chk #(
  .NEURONS (NEURONS),
  .CHUNKS  (CHUNKS),
  .NW      (NW),
  .CW      (CW)
) u_grid_walker_chk (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .neuronId   (neuronId),
  .chunkId    (chunkId),
  .valid      (valid),
  .firstChunk (firstChunk),
  .lastChunk  (lastChunk),
  .done       (done)
);

// File: tb/grid_walker_bench.sv
module grid_walker_bench;

  localparam int PERIOD = 10;
  localparam int NCFG   = 4;
  localparam int NS [NCFG] = '{3, 1, 2, 1};
  localparam int CS [NCFG] = '{4, 1, 1, 3};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;

  logic [NCFG-1:0][7:0] obsN, obsC;
  logic [NCFG-1:0] obsV, obsF, obsL, obsD;

  int compared = 0;
  int mismatched = 0;

  // reference: position since an accepted start
  int  pos [NCFG];
  bit  busy [NCFG];

  always #(PERIOD/2) clk = ~clk;

  for (genvar k = 0; k < NCFG; k++) begin : g_cfg
    localparam int N  = NS[k];
    localparam int C  = CS[k];
    localparam int NW = (N > 1) ? $clog2(N) : 1;
    localparam int CW = (C > 1) ? $clog2(C) : 1;
    logic [NW-1:0] nid;
    logic [CW-1:0] cid;
    grid_walker #(.NEURONS(N), .CHUNKS(C)) u_grid_walker (
      .clk        (clk),
      .rstN       (rstN),
      .start      (start),
      .neuronId   (nid),
      .chunkId    (cid),
      .valid      (obsV[k]),
      .firstChunk (obsF[k]),
      .lastChunk  (obsL[k]),
      .done       (obsD[k])
    );
    assign obsN[k] = 8'(nid);
    assign obsC[k] = 8'(cid);
  end

  task automatic compareAll(input string phase);
    for (int k = 0; k < NCFG; k++) begin
      int total = NS[k] * CS[k];
      bit eV = busy[k] && pos[k] < total;
      bit eD = busy[k] && pos[k] == total;
      int eN = eV ? pos[k] / CS[k] : 0;
      int eC = eV ? pos[k] % CS[k] : 0;
      bit eF = eV && eC == 0;
      bit eL = eV && eC == CS[k] - 1;
      compared++;
      if (obsV[k] !== eV) begin
        mismatched++;
        $display("FAIL R9/R3 %s cfg%0d valid actual=%b expected=%b", phase, k, obsV[k], eV);
      end else if (obsD[k] !== eD) begin
        mismatched++;
        $display("FAIL R6 %s cfg%0d done actual=%b expected=%b", phase, k, obsD[k], eD);
      end else if (obsN[k] !== 8'(eN) || obsC[k] !== 8'(eC)) begin
        mismatched++;
        $display("FAIL R3 %s cfg%0d idx actual=%0d,%0d expected=%0d,%0d",
                 phase, k, obsN[k], obsC[k], eN, eC);
      end else if (obsF[k] !== eF) begin
        mismatched++;
        $display("FAIL R4 %s cfg%0d first actual=%b expected=%b", phase, k, obsF[k], eF);
      end else if (obsL[k] !== eL) begin
        mismatched++;
        $display("FAIL R5 R10 %s cfg%0d last actual=%b expected=%b", phase, k, obsL[k], eL);
      end
    end
  endtask

  task automatic step(input bit s, input string phase);
    start = s;
    @(posedge clk);
    for (int k = 0; k < NCFG; k++) begin
      if (!busy[k]) begin
        if (s) begin busy[k] = 1'b1; pos[k] = 0; end
      end else begin
        pos[k]++;
        if (pos[k] > NS[k] * CS[k]) busy[k] = 1'b0;
      end
    end
    @(negedge clk);
    compareAll(phase);
  endtask

  task automatic doReset();
    start = 1'b0;
    rstN  = 1'b0;
    for (int k = 0; k < NCFG; k++) begin busy[k] = 1'b0; pos[k] = 0; end
    @(posedge clk);
    @(negedge clk);
    compareAll("R1 in reset");
    rstN = 1'b1;
    step(1'b0, "R1 after release");
  endtask

  initial begin
    #(PERIOD * 20000);
    mismatched++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    @(negedge clk);
    doReset();                                     // R1
    step(1'b0, "R9 idle");
    // single pulse: full pass on every shape, then idle (R2 R3 R6 R7)
    step(1'b1, "R2 launch");
    for (int i = 0; i < 16; i++) step(1'b0, "R3 pass");
    // start held: ignored while running and on done, relaunch after (R8 R7)
    for (int i = 0; i < 40; i++) step(1'b1, "R8 held");
    step(1'b0, "R7 drain");
    for (int i = 0; i < 16; i++) step(1'b0, "R7 drain");
    // pulses at every spacing 1..7, landing on all states (R8)
    for (int gap = 1; gap <= 7; gap++)
      for (int i = 0; i < 3 * gap + 6; i++) step((i % gap) == 0, "R8 pulses");
    // reset in the middle of a pass (R1)
    step(1'b1, "R2 launch");
    for (int i = 0; i < 4; i++) step(1'b0, "R3 pass");
    doReset();
    step(1'b1, "R2 relaunch");
    for (int i = 0; i < 16; i++) step(1'b0, "R10 pass");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule